// File: doc/BRIEF.md
# Subroutine Call Machine-Cycle Sequencer

This block steps an 8-bit CPU through its subroutine-call instructions, both the always-taken form and the four flag-conditional forms. It owns the program counter and stack pointer values for the duration of the instruction. It drives one shared memory port with an address, a read strobe, a write strobe and write data. One clock is one machine cycle, and read data is captured at the end of the cycle that requests it.

The sequence reads the two target bytes in address order, least significant first. It then either finishes or spends one idle cycle. After that it pushes the return address, most significant byte first. Whatever byte the bus returns is used unchanged, including a conflict-substituted $FF. A one-clock completion pulse marks the cycle in which the new PC and SP values are visible.

Top module: `call_seq`

## Requirements
- R1: While reset is held and after it is released, the block is idle: no strobes, `done` low, `busy` low, `pc_out` = RESET_PC (0), `sp_out` = RESET_SP ($FFFE).
- R2: Only opcode $CD (always taken) and opcodes of the form 110cc100 ($C4, $CC, $D4, $DC) start a sequence. Any other opcode presented with `start` causes no strobe, no `busy`, no `done`, and leaves `pc_out` unchanged.
- R3: The clock in which a call opcode is accepted is decode (M0), with no memory access. M1 reads address PC+1 and M2 reads address PC+2. Each is a single read cycle, and the write strobe stays low.
- R4: The condition field is opcode bits [4:3]: 00 taken when Z=0, 01 when Z=1, 10 when C=0, 11 when C=1. Flags are sampled in the decode cycle only.
- R5: For a false condition, the clock after M2 shows `done` high, `pc_out` = PC+3, and `sp_out` unchanged. No write strobe is issued.
- R6: For a taken call, M3 follows M2 and has neither strobe active.
- R7: M4 writes the upper byte of PC+3 to address SP-1. M5 writes the lower byte to address SP-2.
- R8: The clock after M5 shows `done` high for exactly one clock. In that clock, `pc_out` = {byte read in M2, byte read in M1} and `sp_out` = SP-2.
- R9: A `start` seen while `busy` is ignored and does not disturb the running sequence.
- R10: All address arithmetic wraps modulo 2^16.
- R11: Read and write strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opcode valid for decode this cycle |
| opcode | input | 8 | Instruction opcode byte |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | Address of the opcode byte, taken with start |
| sp_in | input | 16 | Stack pointer, taken with start |
| mem_rdata | input | 8 | Read data, valid in the cycle the read is requested |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress (M1..M5) |
| done | output | 1 | One-clock completion pulse |

## Verification
A corrupted phase register shows up at the memory port within one cycle. The symptom is a strobe in decode or in the delay cycle, a missing read, or a write at the wrong stack address. A bad latched condition becomes visible at the end of M2, as an early `done` or a spurious M3. A wrong captured operand byte or stack pointer value only surfaces in the completion clock, through `pc_out` and `sp_out`. The bench therefore compares the bus every cycle and both registers in that clock.

// File: rtl/call_seq_pkg.sv
// Shared definitions for the call sequencer: phase encoding, condition
// codes and the opcode constants it decodes. Assumes 8-bit opcodes.
package call_seq_pkg;

    localparam int OPW = 8;
    localparam logic [OPW-1:0] OP_CALL_ALWAYS = 8'hCD;
    localparam logic [2:0]     OP_COND_HI     = 3'b110;
    localparam logic [2:0]     OP_COND_LO     = 3'b100;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_M1   = 3'd1,
        PH_M2   = 3'd2,
        PH_M3   = 3'd3,
        PH_M4   = 3'd4,
        PH_M5   = 3'd5
    } phase_t;

    typedef enum logic [1:0] {
        CC_NZ = 2'b00,
        CC_Z  = 2'b01,
        CC_NC = 2'b10,
        CC_C  = 2'b11
    } cond_t;

endpackage

// File: rtl/call_cond_eval.sv
// Decodes the opcode into call / not-call and evaluates the branch
// condition against the flags. Purely combinational; assumes the caller
// samples the result only in the decode cycle.
module call_cond_eval
    import call_seq_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    input  logic           flag_z,
    input  logic           flag_c,
    output logic           is_call,
    output logic           take_now
);

    logic  uncond;
    logic  is_cond;
    logic  cond_ok;
    cond_t cc;

    // Classify opcode and test the selected flag.
    always_comb begin
        uncond  = (opcode == OP_CALL_ALWAYS);
        is_cond = (opcode[7:5] == OP_COND_HI) && (opcode[2:0] == OP_COND_LO);
        cc      = cond_t'(opcode[4:3]);
        unique case (cc)
            CC_NZ:   cond_ok = !flag_z;
            CC_Z:    cond_ok =  flag_z;
            CC_NC:   cond_ok = !flag_c;
            CC_C:    cond_ok =  flag_c;
            default: cond_ok = 1'b0;
        endcase
        is_call  = uncond || is_cond;
        take_now = uncond || (is_cond && cond_ok);
    end

endmodule

// File: rtl/call_phase_ctrl.sv
// Machine-cycle state machine. Advances M1 -> M2, then either ends or runs
// M3 -> M4 -> M5. Raises done for one clock after the last cycle.
// Assumes accept is only asserted while idle.
module call_phase_ctrl
    import call_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  logic   take_q,
    output phase_t phase,
    output logic   done
);

    phase_t phase_nx;
    logic   finish;

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        finish   = 1'b0;
        unique case (phase)
            PH_IDLE: if (accept) phase_nx = PH_M1;
            PH_M1:   phase_nx = PH_M2;
            PH_M2:   begin
                if (take_q) begin
                    phase_nx = PH_M3;
                end else begin
                    phase_nx = PH_IDLE;
                    finish   = 1'b1;
                end
            end
            PH_M3:   phase_nx = PH_M4;
            PH_M4:   phase_nx = PH_M5;
            PH_M5:   begin
                phase_nx = PH_IDLE;
                finish   = 1'b1;
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase and completion-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= finish;
        end
    end

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE)); // R5

endmodule

// File: rtl/call_addr_regs.sv
// Holds PC, SP, the latched condition and the two captured operand bytes.
// PC keeps the opcode address until the final cycle; SP steps down once
// per stack write. Assumes read data is valid in the requesting cycle.
module call_addr_regs
    import call_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2 * DW,
    parameter logic [AW-1:0] RESET_PC = '0,
    parameter logic [AW-1:0] RESET_SP = '1 - 1
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          take_now,
    input  phase_t        phase,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] sp_q,
    output logic          take_q,
    output logic [DW-1:0] op_lo,
    output logic [DW-1:0] op_hi
);

    localparam logic [AW-1:0] STEP1 = AW'(1);
    localparam logic [AW-1:0] STEP3 = AW'(3);

    // Program counter: load on accept, advance on skip, jump after M5.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (accept) begin
            pc_q <= pc_in;
        end else if (phase == PH_M2 && !take_q) begin
            pc_q <= pc_q + STEP3;
        end else if (phase == PH_M5) begin
            pc_q <= {op_hi, op_lo};
        end
    end

    // Stack pointer: load on accept, pre-decrement per push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= RESET_SP;
        end else if (accept) begin
            sp_q <= sp_in;
        end else if (phase == PH_M4 || phase == PH_M5) begin
            sp_q <= sp_q - STEP1;
        end
    end

    // Condition latch and operand byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            op_lo  <= '0;
            op_hi  <= '0;
        end else begin
            if (accept)           take_q <= take_now;
            if (phase == PH_M1)   op_lo  <= rdata;
            if (phase == PH_M2)   op_hi  <= rdata;
        end
    end

endmodule

// File: rtl/call_seq.sv
// Top of the call sequencer. Accepts a call opcode while idle, then drives
// the memory port per machine cycle from the phase and the held PC/SP.
// Assumes a zero-latency read port and one clock per machine cycle.
module call_seq
    import call_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] RESET_PC = '0,
    parameter logic [2*DW-1:0] RESET_SP = '1 - 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OPW-1:0]    opcode,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [2*DW-1:0]   pc_in,
    input  logic [2*DW-1:0]   sp_in,
    input  logic [DW-1:0]     mem_rdata,
    output logic [2*DW-1:0]   mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     mem_wdata,
    output logic [2*DW-1:0]   pc_out,
    output logic [2*DW-1:0]   sp_out,
    output logic              busy,
    output logic              done
);

    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] STEP1 = AW'(1);
    localparam logic [AW-1:0] STEP2 = AW'(2);
    localparam logic [AW-1:0] STEP3 = AW'(3);

    phase_t        phase;
    logic          is_call;
    logic          take_now;
    logic          take_q;
    logic          accept;
    logic [DW-1:0] op_lo;
    logic [DW-1:0] op_hi;
    logic [AW-1:0] ret_addr;

    call_cond_eval u_cond (
        .opcode   (opcode),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .is_call  (is_call),
        .take_now (take_now)
    );

    call_phase_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .take_q (take_q),
        .phase  (phase),
        .done   (done)
    );

    call_addr_regs #(
        .DW       (DW),
        .AW       (AW),
        .RESET_PC (RESET_PC),
        .RESET_SP (RESET_SP)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .take_now (take_now),
        .phase    (phase),
        .pc_in    (pc_in),
        .sp_in    (sp_in),
        .rdata    (mem_rdata),
        .pc_q     (pc_out),
        .sp_q     (sp_out),
        .take_q   (take_q),
        .op_lo    (op_lo),
        .op_hi    (op_hi)
    );

    // Start acceptance: only a call opcode, only while idle.
    always_comb begin
        busy     = (phase != PH_IDLE);
        accept   = start && is_call && !busy;
        ret_addr = pc_out + STEP3;
    end

    // Memory port drive per machine cycle.
    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        unique case (phase)
            PH_M1: begin
                mem_addr = pc_out + STEP1;
                mem_rd   = 1'b1;
            end
            PH_M2: begin
                mem_addr = pc_out + STEP2;
                mem_rd   = 1'b1;
            end
            PH_M4: begin
                mem_addr  = sp_out - STEP1;
                mem_wr    = 1'b1;
                mem_wdata = ret_addr[AW-1:DW];
            end
            PH_M5: begin
                mem_addr  = sp_out - STEP1;
                mem_wr    = 1'b1;
                mem_wdata = ret_addr[DW-1:0];
            end
            default: begin
                mem_addr  = '0;
            end
        endcase
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr)); // R2

    AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_M3) |-> (!mem_rd && !mem_wr)); // R6

    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp_out == $past(sp_out) - STEP1)); // R7

    AST_SKIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_wr && !take_q && phase == PH_M2) |=> (done && pc_out == $past(pc_out) + STEP3)); // R5

    AST_BUSY_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != PH_M2 && phase != PH_M5) |=> $stable(pc_out)); // R9

endmodule

// File: tb/call_seq_test.sv
module call_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  opcode;
    logic        flag_z, flag_c;
    logic [15:0] pc_in, sp_in;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [15:0] pc_out, sp_out;
    logic        busy, done;
    logic        lock_on;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    call_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .flag_z(flag_z), .flag_c(flag_c), .pc_in(pc_in), .sp_in(sp_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .pc_out(pc_out),
        .sp_out(sp_out), .busy(busy), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        if (lock_on && a[15:8] == 8'hFE) return 8'hFF;
        return (a[7:0] ^ 8'h3C) + a[15:8] + 8'h11;
    endfunction

    assign mem_rdata = mem_byte(mem_addr);

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // One call; checks every machine cycle at the negedge.
    task automatic run_call(input logic [7:0] op, input logic [15:0] pc0,
                            input logic [15:0] sp0, input logic z,
                            input logic c, input bit take, input bit poke);
        logic [15:0] ret;
        logic [7:0]  lo, hi;
        ret = pc0 + 16'd3;
        lo  = mem_byte(pc0 + 16'd1);
        hi  = mem_byte(pc0 + 16'd2);
        @(negedge clk);
        start = 1'b1; opcode = op; pc_in = pc0; sp_in = sp0;
        flag_z = z; flag_c = c;
        chk("R3", "M0 strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
        @(negedge clk);
        start = poke; pc_in = 16'h1234; sp_in = 16'h4321; opcode = 8'hCD;
        flag_z = ~z; flag_c = ~c;   // R4: flags after decode must not matter
        chk("R3", "M1 strobes", {14'd0, mem_rd, mem_wr}, 16'd2);
        chk("R10", "M1 addr", mem_addr, pc0 + 16'd1);
        @(negedge clk);
        start = 1'b0;
        chk("R3", "M2 strobes", {14'd0, mem_rd, mem_wr}, 16'd2);
        chk("R10", "M2 addr", mem_addr, pc0 + 16'd2);
        if (!take) begin
            @(negedge clk);
            chk("R5", "skip done", {15'd0, done}, 16'd1);
            chk("R5", "skip pc", pc_out, ret);
            chk("R5", "skip sp", sp_out, sp0);
            chk("R5", "skip strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
        end else begin
            @(negedge clk);
            chk("R6", "M3 strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
            chk("R6", "M3 no done", {15'd0, done}, 16'd0);
            @(negedge clk);
            chk("R7", "M4 strobes", {14'd0, mem_rd, mem_wr}, 16'd1);
            chk("R7", "M4 addr", mem_addr, sp0 - 16'd1);
            chk("R7", "M4 data", {8'd0, mem_wdata}, {8'd0, ret[15:8]});
            @(negedge clk);
            chk("R7", "M5 strobes", {14'd0, mem_rd, mem_wr}, 16'd1);
            chk("R7", "M5 addr", mem_addr, sp0 - 16'd2);
            chk("R7", "M5 data", {8'd0, mem_wdata}, {8'd0, ret[7:0]});
            @(negedge clk);
            chk("R8", "done", {15'd0, done}, 16'd1);
            chk("R8", "target pc", pc_out, {hi, lo});
            chk("R8", "final sp", sp_out, sp0 - 16'd2);
        end
        @(negedge clk);
        chk("R8", "done single clock", {15'd0, done}, 16'd0);
        chk("R8", "idle after", {15'd0, busy}, 16'd0);
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] pc_keep;
        rst_n = 1'b0; start = 1'b0; opcode = 8'h00; flag_z = 1'b0;
        flag_c = 1'b0; pc_in = 16'h0; sp_in = 16'h0; lock_on = 1'b0;
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1", "reset strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset pc", pc_out, 16'h0000);
        chk("R1", "reset sp", sp_out, 16'hFFFE);
        chk("R1", "reset busy/done", {14'd0, busy, done}, 16'd0);

        // R2: every non-call opcode is ignored
        for (int i = 0; i < 256; i++) begin
            logic [7:0] op;
            op = 8'(i);
            if (op == 8'hCD || (op[7:5] == 3'b110 && op[2:0] == 3'b100))
                continue;
            pc_keep = pc_out;
            start = 1'b1; opcode = op; pc_in = 16'hABCD; sp_in = 16'h2222;
            @(negedge clk);
            start = 1'b0;
            chk("R2", $sformatf("op %h quiet", op),
                {13'd0, mem_rd, mem_wr, busy}, 16'd0);
            @(negedge clk);
            chk("R2", $sformatf("op %h no done/pc", op),
                pc_out ^ {15'd0, done}, pc_keep);
        end

        // R4: all condition codes against all flag combinations
        for (int cc = 0; cc < 4; cc++) begin
            for (int f = 0; f < 4; f++) begin
                logic z, c;
                bit tk;
                z = f[0]; c = f[1];
                case (cc)
                    0: tk = !z;
                    1: tk = z;
                    2: tk = !c;
                    default: tk = c;
                endcase
                run_call(8'hC4 | 8'(cc << 3), 16'h0200 + 16'(cc * 16 + f),
                         16'hD000 + 16'(f), z, c, tk, 1'b0);
            end
        end

        // Unconditional call at several addresses, including wrap (R10)
        run_call(8'hCD, 16'h0150, 16'hFFFE, 1'b0, 1'b0, 1'b1, 1'b0);
        run_call(8'hCD, 16'hFFFE, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0);
        run_call(8'hCD, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0);
        run_call(8'hDC, 16'hFFFD, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0);

        // R9: start during busy ignored (taken and skipped)
        run_call(8'hCD, 16'h4000, 16'hC000, 1'b0, 1'b0, 1'b1, 1'b1);
        run_call(8'hCC, 16'h4100, 16'hC100, 1'b0, 1'b0, 1'b0, 1'b1);

        // R8: high operand byte in a locked region comes back as $FF
        lock_on = 1'b1;
        run_call(8'hCD, 16'hFDFE, 16'hDFFF, 1'b0, 1'b0, 1'b1, 1'b0);
        run_call(8'hD4, 16'hFDFE, 16'hDFF0, 1'b0, 1'b0, 1'b1, 1'b0);
        lock_on = 1'b0;

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule